// File: doc/BRIEF.md
# Integer Execute Unit

This block decodes one 32-bit integer instruction word and computes its result. It covers ten arithmetic, compare, shift and logic operations, and it also forms the address for word loads and stores. The caller reads the register file and presents the values of the two source registers with the instruction: `in_rs_val` holds the value of the register named in bits 25:21, and `in_rt_val` holds the value named in bits 20:16. One cycle later the block returns the result, the destination register index and a write strobe.

Instructions follow the fixed 32-bit layouts. The register layout is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. The immediate layout is opcode[31:26], rs[25:21], rt[20:16] and imm[15:0]. The unit does not access memory, resolve branches or trap on overflow. The write strobe is never raised for register 0, so that register always reads as zero.

The output stage is a two-state machine. `ST_EMPTY` holds no result. `ST_FULL` holds the result of the instruction accepted on the previous edge. The *load* transition goes from either state to `ST_FULL` when `in_valid` is high at an edge. The *drain* transition goes from either state to `ST_EMPTY` when `in_valid` is low. Reset forces `ST_EMPTY`.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted instruction, `out_valid`, `out_wen` and `out_result` are 0.
- R2: An instruction presented with `in_valid` high at a rising edge appears on the outputs right after that edge, with `out_valid` high. After an edge where `in_valid` is low, `out_valid` and `out_wen` are 0.
- R3: With opcode 0, funct 32 (add) gives rs+rt and funct 34 (sub) gives rs-rt. Both wrap modulo 2^32 without any trap, and both write to rd (bits 15:11).
- R4: With opcode 0, funct 42 (slt) gives 1 if rs < rt as signed numbers and 0 otherwise. Opcode 10 (slti) makes the same comparison of rs against the sign-extended immediate. Each writes 0 or 1.
- R5: With opcode 0, funct 0 (sll) shifts the rt value left by shamt (bits 10:6), and funct 2 (srl) shifts it right by shamt. Vacated bits are zero and the rs value is unused.
- R6: Opcode 8 (addi) gives rs plus the sign-extended immediate and writes to rt (bits 20:16).
- R7: Opcode 12 (andi) and opcode 13 (ori) combine rs with the zero-extended immediate, using AND and OR respectively.
- R8: Opcode 15 (lui) gives the immediate in bits 31:16 and zeros in bits 15:0, and ignores the rs value. Applying lui 61 and then ori 2304 builds 0x003D0900.
- R9: Opcode 35 (load word) and opcode 43 (store word) output the address rs + sign-extended offset, with rt as the destination. The load raises `out_wen`; the store never does.
- R10: When the destination index is 0, `out_wen` stays low, but the result is still shown.
- R11: An unknown opcode, or opcode 0 with an unknown funct, gives `out_result` 0 and `out_wen` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the register in bits 25:21 |
| in_rt_val | input | 32 | Value of the register in bits 20:16 |
| out_valid | output | 1 | A result is held on the outputs |
| out_result | output | 32 | Computed value or memory address |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | Register write strobe |

## Verification
The assertions check properties that hold on every cycle:
- the write strobe is never raised for register 0 or while the output is empty;
- an accepted instruction is always followed by a valid output;
- a compare result is only 0 or 1;
- a result after a non-zero right shift has a clear top bit;
- a lui result has a clear low half;
- an unknown instruction gives a zero result with no write.

Only the bench scenarios can show that each value is arithmetically right. These include:
- signed comparisons across the sign boundary;
- wrap-around on add;
- extension of negative and high-bit immediates;
- the lui-then-ori constant;
- store versus load write behaviour.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;

    // primary opcodes
    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI    = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LW      = 6'd35;
    localparam logic [OPC_W-1:0] OPC_SW      = 6'd43;

    // function codes under OPC_SPECIAL
    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_SLT, K_SLL, K_SRL, K_AND, K_OR, K_LUI
    } alu_kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsel_e;

    typedef struct packed {
        alu_kind_e        kind;
        bsel_e            bsel;
        logic [REG_W-1:0] dest;
        logic             wen;
        logic [REG_W-1:0] shamt;
        logic [IMM_W-1:0] imm;
    } ctrl_t;

    typedef enum logic {
        ST_EMPTY, ST_FULL
    } stage_st_e;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);

    localparam int OPC_LO = INSTR_W - OPC_W;
    localparam int RS_LO  = OPC_LO - REG_W;
    localparam int RT_LO  = RS_LO - REG_W;
    localparam int RD_LO  = RT_LO - REG_W;
    localparam int SH_LO  = RD_LO - REG_W;

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] f_rt, f_rd, f_sh;
    logic [5:0]       f_fn;
    logic             raw_wen;
    logic [REG_W-1:0] raw_dest;

    assign opc  = instr[INSTR_W-1:OPC_LO];
    assign f_rt = instr[RS_LO-1:RT_LO];
    assign f_rd = instr[RT_LO-1:RD_LO];
    assign f_sh = instr[RD_LO-1:SH_LO];
    assign f_fn = instr[SH_LO-1:0];

    always_comb begin
        ctrl.kind  = K_NONE;
        ctrl.bsel  = B_REG;
        ctrl.shamt = f_sh;
        ctrl.imm   = instr[IMM_W-1:0];
        raw_dest   = f_rt;
        raw_wen    = 1'b0;
        unique case (opc)
            OPC_SPECIAL: begin
                raw_dest = f_rd;
                raw_wen  = 1'b1;
                unique case (f_fn)
                    FN_ADD:  ctrl.kind = K_ADD;
                    FN_SUB:  ctrl.kind = K_SUB;
                    FN_SLT:  ctrl.kind = K_SLT;
                    FN_SLL:  ctrl.kind = K_SLL;
                    FN_SRL:  ctrl.kind = K_SRL;
                    default: raw_wen   = 1'b0;
                endcase
            end
            OPC_ADDI: begin ctrl.kind = K_ADD; ctrl.bsel = B_SEXT; raw_wen = 1'b1; end
            OPC_SLTI: begin ctrl.kind = K_SLT; ctrl.bsel = B_SEXT; raw_wen = 1'b1; end
            OPC_ANDI: begin ctrl.kind = K_AND; ctrl.bsel = B_ZEXT; raw_wen = 1'b1; end
            OPC_ORI:  begin ctrl.kind = K_OR;  ctrl.bsel = B_ZEXT; raw_wen = 1'b1; end
            OPC_LUI:  begin ctrl.kind = K_LUI; ctrl.bsel = B_ZEXT; raw_wen = 1'b1; end
            OPC_LW:   begin ctrl.kind = K_ADD; ctrl.bsel = B_SEXT; raw_wen = 1'b1; end
            OPC_SW:   begin ctrl.kind = K_ADD; ctrl.bsel = B_SEXT; raw_wen = 1'b0; end
            default:  raw_wen = 1'b0;
        endcase
        ctrl.dest = raw_dest;
        // register 0 is hard-wired: never strobe a write to it (R10)
        ctrl.wen  = raw_wen && (raw_dest != '0);
    end

endmodule

// File: rtl/exu_operand.sv
module exu_operand
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bsel_e             bsel,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] opb
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_s, imm_z;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_s = {{EXT_W{imm[IMM_W-1]}}, imm};
            assign imm_z = {{EXT_W{1'b0}}, imm};
        end else begin : g_noext
            assign imm_s = imm[DATA_W-1:0];
            assign imm_z = imm[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (bsel)
            B_SEXT:  opb = imm_s;
            B_ZEXT:  opb = imm_z;
            default: opb = rt_val;
        endcase
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_kind_e         kind,
    input  logic [REG_W-1:0]  shamt,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] result
);

    localparam int UP_SH = DATA_W - IMM_W;

    logic signed [DATA_W-1:0] sa, sb;
    logic                     less;

    assign sa   = opa;
    assign sb   = opb;
    assign less = (sa < sb);

    always_comb begin
        unique case (kind)
            K_ADD:   result = opa + opb;
            K_SUB:   result = opa - opb;
            K_SLT:   result = {{(DATA_W-1){1'b0}}, less};
            K_SLL:   result = rt_val << shamt;
            K_SRL:   result = rt_val >> shamt;
            K_AND:   result = opa & opb;
            K_OR:    result = opa | opb;
            K_LUI:   result = opb << UP_SH;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [31:0]       in_rs_val,
    input  logic [31:0]       in_rt_val,
    output logic              out_valid,
    output logic [31:0]       out_result,
    output logic [4:0]        out_dest,
    output logic              out_wen
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;

    stage_st_e         st_q, st_d;
    alu_kind_e         kind_q;
    logic [REG_W-1:0]  shamt_q;

    exu_decode u_dec (
        .instr (in_instr),
        .ctrl  (ctrl)
    );

    exu_operand #(.DATA_W(DATA_W)) u_opb (
        .bsel   (ctrl.bsel),
        .imm    (ctrl.imm),
        .rt_val (in_rt_val),
        .opb    (opb)
    );

    exu_alu #(.DATA_W(DATA_W)) u_alu (
        .kind   (ctrl.kind),
        .shamt  (ctrl.shamt),
        .opa    (in_rs_val),
        .opb    (opb),
        .rt_val (in_rt_val),
        .result (alu_res)
    );

    // next-state: load on an accepted instruction, drain otherwise
    always_comb begin
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_dest   <= '0;
            out_wen    <= 1'b0;
            kind_q     <= K_NONE;
            shamt_q    <= '0;
        end else if (st_d == ST_FULL) begin
            out_result <= alu_res;
            out_dest   <= ctrl.dest;
            out_wen    <= ctrl.wen;
            kind_q     <= ctrl.kind;
            shamt_q    <= ctrl.shamt;
        end else begin
            out_wen    <= 1'b0;
        end
    end

    assign out_valid = (st_q == ST_FULL);

    // ---------------- assertions ----------------
    p_no_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> (out_dest != '0));

    p_quiet_when_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_wen);

    p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_cmp_boolean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_SLT) |-> (out_result[DATA_W-1:1] == '0));

    p_srl_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_SRL && shamt_q != '0) |-> !out_result[DATA_W-1]);

    p_lui_low_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_LUI) |-> (out_result[IMM_W-1:0] == '0));

    p_unknown_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_NONE) |-> (!out_wen && out_result == '0));

endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_rs_val = '0;
    logic [31:0] in_rt_val = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_dest;
    logic        out_wen;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .out_valid(out_valid),
        .out_result(out_result), .out_dest(out_dest), .out_wen(out_wen)
    );

    typedef struct {
        bit          v;
        logic [31:0] res;
        logic [4:0]  dst;
        bit          wen;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] itype(input int op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op[5:0], rs[4:0], rt[4:0], imm};
    endfunction

    task automatic send(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] res, input logic [4:0] dst, input bit wen,
                        input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; in_rs_val = a; in_rt_val = b;
        e.v = 1; e.res = res; e.dst = dst; e.wen = wen; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bubble(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; in_instr = 32'hFFFF_FFFF;
        e.v = 0; e.res = '0; e.dst = '0; e.wen = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: one scoreboard item per edge, sampled just after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.v) begin
                if (!out_valid || out_result !== e.res || out_dest !== e.dst || out_wen !== e.wen) begin
                    errors++;
                    $display("FAIL %s: got v=%0b res=%h dst=%0d wen=%0b, expected v=1 res=%h dst=%0d wen=%0b",
                             e.tag, out_valid, out_result, out_dest, out_wen, e.res, e.dst, e.wen);
                end
            end else begin
                if (out_valid !== 1'b0 || out_wen !== 1'b0) begin
                    errors++;
                    $display("FAIL %s: got v=%0b wen=%0b, expected v=0 wen=0",
                             e.tag, out_valid, out_wen);
                end
            end
        end
    end

    task automatic check_reset(input string tag);
        checks++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_result !== 32'h0) begin
            errors++;
            $display("FAIL %s: got v=%0b wen=%0b res=%h, expected v=0 wen=0 res=0",
                     tag, out_valid, out_wen, out_result);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check_reset("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset("R1 after release");

        // R3 add / sub
        send(rtype(1, 2, 9, 0, 32), 32'd5, 32'd7, 32'd12, 5'd9, 1, "R3 add");
        send(rtype(1, 2, 9, 0, 32), 32'hFFFF_FFFF, 32'd2, 32'd1, 5'd9, 1, "R3 add wrap");
        send(rtype(3, 4, 17, 0, 34), 32'd3, 32'd5, 32'hFFFF_FFFE, 5'd17, 1, "R3 sub");
        // R2 bubble between accepted instructions
        bubble("R2 bubble");
        // R4 signed compares
        send(rtype(1, 2, 8, 0, 42), 32'hFFFF_FFFF, 32'd1, 32'd1, 5'd8, 1, "R4 slt neg<pos");
        send(rtype(1, 2, 8, 0, 42), 32'd1, 32'hFFFF_FFFF, 32'd0, 5'd8, 1, "R4 slt pos>neg");
        send(rtype(1, 2, 8, 0, 42), 32'd6, 32'd6, 32'd0, 5'd8, 1, "R4 slt equal");
        send(itype(10, 1, 12, 16'hFFFC), 32'hFFFF_FFFB, 32'h0, 32'd1, 5'd12, 1, "R4 slti -5<-4");
        send(itype(10, 1, 12, 16'h0007), 32'd7, 32'h0, 32'd0, 5'd12, 1, "R4 slti 7<7");
        // R5 shifts, rs value is garbage
        send(rtype(0, 2, 10, 31, 0), 32'hDEAD_BEEF, 32'd1, 32'h8000_0000, 5'd10, 1, "R5 sll 31");
        send(rtype(0, 2, 10, 4, 0), 32'h1234_5678, 32'd3, 32'h0000_0030, 5'd10, 1, "R5 sll 4");
        send(rtype(0, 2, 10, 31, 2), 32'hDEAD_BEEF, 32'h8000_0000, 32'd1, 5'd10, 1, "R5 srl 31");
        send(rtype(0, 2, 10, 4, 2), 32'h0, 32'hF000_0000, 32'h0F00_0000, 5'd10, 1, "R5 srl zero fill");
        // R6 addi
        send(itype(8, 19, 19, 16'h0001), 32'd41, 32'h5555_5555, 32'd42, 5'd19, 1, "R6 addi +1");
        send(itype(8, 19, 19, 16'hFFFF), 32'd10, 32'h0, 32'd9, 5'd19, 1, "R6 addi -1");
        // R7 logical immediates
        send(itype(12, 1, 6, 16'h8000), 32'hFFFF_FFFF, 32'h0, 32'h0000_8000, 5'd6, 1, "R7 andi zext");
        send(itype(13, 1, 6, 16'hF000), 32'h0000_0001, 32'h0, 32'h0000_F001, 5'd6, 1, "R7 ori zext");
        // R8 lui then ori builds a constant
        send(itype(15, 3, 8, 16'd61), 32'h0000_0123, 32'h0, 32'h003D_0000, 5'd8, 1, "R8 lui 61");
        send(itype(13, 8, 8, 16'd2304), 32'h003D_0000, 32'h0, 32'h003D_0900, 5'd8, 1, "R8 ori 2304");
        // R9 address generation
        send(itype(35, 22, 8, 16'hFFFC), 32'd1000, 32'h0, 32'd996, 5'd8, 1, "R9 lw");
        send(itype(43, 22, 8, 16'h0008), 32'h0000_0100, 32'hAAAA_AAAA, 32'h0000_0108, 5'd8, 0, "R9 sw");
        // R10 writes to register 0 suppressed
        send(rtype(1, 2, 0, 0, 32), 32'd5, 32'd7, 32'd12, 5'd0, 0, "R10 add to r0");
        send(itype(8, 1, 0, 16'h0003), 32'd4, 32'h0, 32'd7, 5'd0, 0, "R10 addi to r0");
        // R11 unknown encodings
        send(itype(63, 1, 5, 16'h1234), 32'd9, 32'd9, 32'd0, 5'd5, 0, "R11 unknown opcode");
        send(rtype(1, 2, 7, 0, 1), 32'd9, 32'd9, 32'd0, 5'd7, 0, "R11 unknown funct");
        bubble("R2 drain");
        bubble("R2 stay empty");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule